// File: doc/BRIEF.md
# Four-Lane Parallel Linear-Phase FIR Filter

This block is an 11-tap FIR filter with fixed coefficients and even symmetry. It runs at a sample rate four times its clock rate. On every clock it accepts one 64-bit word that carries four consecutive signed 16-bit samples, each with 15 fractional bits. Four clocks later it returns one 64-bit word that carries the four matching filtered samples in the same packing.

Each output lane needs its own sample together with the ten samples before it, and some of those ten come from earlier words. The block therefore keeps a ten-sample history in registers. For each lane it folds the mirrored tap pairs through pre-adders, multiplies each fold by a constant, and sums the six products in a wide accumulator. It then picks out a 16-bit field of that sum to form the result.

The filter is meant for a continuous stream with the input valid held high. When a word arrives with valid low, that word is not entered into the history.

Top module: `fir4_par`

## Requirements
- R1: Lane n of both data words sits at bits [16n+15:16n]. Lane 0 carries the oldest sample of the word and lane 3 the newest.
- R2: Each output sample is y[i] = sum over k=0..10 of h[k]*x[i-k]. The integer coefficients are h[0..5] = 190, -32, 333, -154, 3096, 23977, with h[k] = h[10-k].
- R3: The samples that feed lane n continue across word boundaries in stream order. Lane 0 of a word uses the last ten samples of the earlier valid words.
- R4: The output sample is bits [30:15] of the exact signed sum, which is an arithmetic shift right by 15 followed by keeping the low 16 bits. Full-scale inputs of either sign produce no overflow.
- R5: The data of the word sampled at clock edge e appears on out_data just after edge e+3, a fixed latency of four registers.
- R6: out_valid equals in_valid as sampled four edges earlier, so it stays high without gaps while in_valid stays high.
- R7: A word sampled with in_valid low does not enter the history. Its output slot repeats the previous output word, and the next valid word continues from the last valid samples.
- R8: While rst is high at a clock edge, the history, the pipeline registers and out_valid clear to zero. After reset, the output is zero for four edges and later outputs treat all earlier samples as zero.
- R9: Four consecutive valid all-zero input words produce an all-zero output word at the slot of the last of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 64 | Four packed input samples, lane 0 oldest |
| out_valid | output | 1 | Output word qualifier, four clocks behind in_valid |
| out_data | output | 64 | Four packed filtered samples, lane 0 oldest |

## Verification
Two functions can meet in the same cycle: the history hold for a word with valid low, and the cross-word tap window for the next valid word. That next word must reach back past the gap to the last valid samples. The bench provokes this by dropping valid at random during random data and during impulse patterns placed at lane 3. It judges the result against a model that builds the sample stream only from valid words and expects a repeated output in the slot of every dropped word. A mid-run reset is also placed directly after a dropped word, to check that clearing wins over the hold.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  // filter shape
  localparam int unsigned TAPS   = 11;
  localparam int unsigned COEF_W = 16;
  localparam int unsigned FRAC   = 15;

  // Mirrored coefficient lookup: index 0 is the outermost tap.
  function automatic logic signed [COEF_W-1:0] tap_coef(input int unsigned idx);
    int unsigned m;
    m = (idx > TAPS - 1 - idx) ? (TAPS - 1 - idx) : idx;
    case (m)
      0:       tap_coef = 16'sd190;
      1:       tap_coef = -16'sd32;
      2:       tap_coef = 16'sd333;
      3:       tap_coef = -16'sd154;
      4:       tap_coef = 16'sd3096;
      default: tap_coef = 16'sd23977;
    endcase
  endfunction

endpackage

// File: rtl/fir4_history.sv
// Keeps the last TAPS-1 samples and presents a window of HIST+LANES samples,
// oldest at the lowest bits. Only valid words advance the history.
module fir4_history #(
  parameter int unsigned LANES = 4,
  parameter int unsigned SW    = 16,
  parameter int unsigned HIST  = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [LANES*SW-1:0]         in_data,
  output logic [(HIST+LANES)*SW-1:0]  win_q
);

  localparam int unsigned WIN_W  = (HIST + LANES) * SW;
  localparam int unsigned HIST_W = HIST * SW;

  logic [HIST_W-1:0] hist_q;
  logic [WIN_W-1:0]  joined;

  // new samples sit above the history: stream order runs low to high
  assign joined = {in_data, hist_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      win_q  <= '0;
    end else if (in_valid) begin
      hist_q <= joined[WIN_W-1 -: HIST_W];
      win_q  <= joined;
    end
  end

endmodule

// File: rtl/fir4_vpipe.sv
// Delay line for the word qualifier, matched to the data path depth.
module fir4_vpipe #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[DEPTH-2:0], d};
  end

  assign q = sr_q[DEPTH-1];

endmodule

// File: rtl/fir4_lane.sv
// One output phase: folded pre-add, constant multiply, sum, field select.
// Three register stages.
module fir4_lane #(
  parameter int unsigned SW   = 16,
  parameter int unsigned TAPS = 11,
  parameter int unsigned CW   = 16,
  parameter int unsigned AW   = 36,
  parameter int unsigned FRAC = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TAPS*SW-1:0]     win,
  output logic [SW-1:0]          y_q
);

  localparam int unsigned NPAIR   = TAPS / 2;
  localparam int unsigned HAS_MID = TAPS % 2;
  localparam int unsigned NPROD   = NPAIR + HAS_MID;
  localparam int unsigned PW      = SW + 1;
  localparam int unsigned MW      = PW + CW;
  localparam int unsigned HI_W    = AW - FRAC - SW;

  logic signed [SW-1:0] x     [TAPS];
  logic signed [PW-1:0] pa_q  [NPROD];
  logic signed [MW-1:0] pr_q  [NPROD];
  logic signed [AW-1:0] acc;
  logic [SW-1:0]        y_next;
  logic [FRAC-1:0]      frac_unused;
  logic [HI_W-1:0]      sign_unused;

  // unpack the window; index TAPS-1 is the newest sample
  for (genvar j = 0; j < TAPS; j++) begin : g_unpack
    assign x[j] = win[j*SW +: SW];
  end

  // stage 1: fold mirrored taps
  for (genvar p = 0; p < NPAIR; p++) begin : g_fold
    always_ff @(posedge clk) begin
      if (rst) pa_q[p] <= '0;
      else     pa_q[p] <= PW'(x[TAPS-1-p]) + PW'(x[p]);
    end
  end

  if (HAS_MID != 0) begin : g_mid
    always_ff @(posedge clk) begin
      if (rst) pa_q[NPAIR] <= '0;
      else     pa_q[NPAIR] <= PW'(x[NPAIR]);
    end
  end

  // stage 2: constant multiplies
  for (genvar p = 0; p < NPROD; p++) begin : g_mul
    localparam logic signed [CW-1:0] C = fir4_pkg::tap_coef(p);
    always_ff @(posedge clk) begin
      if (rst) pr_q[p] <= '0;
      else     pr_q[p] <= pa_q[p] * C;
    end
  end

  // stage 3: full-width sum, then keep the Q15 field (wraps, no saturation)
  always_comb begin
    acc = '0;
    for (int p = 0; p < NPROD; p++) begin
      acc = acc + AW'(pr_q[p]);
    end
  end

  assign {sign_unused, y_next, frac_unused} = acc;

  always_ff @(posedge clk) begin
    if (rst) y_q <= '0;
    else     y_q <= y_next;
  end

endmodule

// File: rtl/fir4_par.sv
module fir4_par #(
  parameter int unsigned LANES = 4,
  parameter int unsigned SW    = 16,
  parameter int unsigned AW    = 36
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [LANES*SW-1:0]   in_data,
  output logic                  out_valid,
  output logic [LANES*SW-1:0]   out_data
);

  localparam int unsigned TAPS = fir4_pkg::TAPS;
  localparam int unsigned HIST = TAPS - 1;
  localparam int unsigned WIN  = HIST + LANES;
  localparam int unsigned LAT  = 4;   // history reg + three lane stages

  logic [WIN*SW-1:0] win_q;

  fir4_history #(
    .LANES (LANES),
    .SW    (SW),
    .HIST  (HIST)
  ) i_hist (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .win_q    (win_q)
  );

  // lane n is computed from window samples n .. n+TAPS-1
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    fir4_lane #(
      .SW   (SW),
      .TAPS (TAPS),
      .CW   (fir4_pkg::COEF_W),
      .AW   (AW),
      .FRAC (fir4_pkg::FRAC)
    ) i_lane (
      .clk (clk),
      .rst (rst),
      .win (win_q[n*SW +: TAPS*SW]),
      .y_q (out_data[n*SW +: SW])
    );
  end

  fir4_vpipe #(
    .DEPTH (LAT)
  ) i_vpipe (
    .clk (clk),
    .rst (rst),
    .d   (in_valid),
    .q   (out_valid)
  );

endmodule

// File: rtl/fir4_par_chk.sv
module fir4_par_chk #(
  parameter int unsigned DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);

  // count of clean edges since reset, saturating
  logic [2:0] cnt_q;
  logic       zero_word;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
  end

  assign zero_word = in_valid && (in_data == '0);

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R6
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R7
  gap_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= 3'd5 && !$past(in_valid, 4)) |-> $stable(out_data));

  // R9
  zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= 3'd3 && zero_word && $past(zero_word) && $past(zero_word, 2)
     && $past(zero_word, 3)) |-> ##4 (out_data == '0));

endmodule

bind fir4_par fir4_par_chk #(.DW(LANES*SW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_fir4_par.sv
module test_fir4_par;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  fir4_par i_fir4_par (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // ---------------- reference model ----------------
  int          mh [10];
  logic [63:0] last_exp = '0;
  bit          ring_r [8];
  bit          ring_v [8];
  logic [63:0] ring_d [8];
  int          k = 0;

  function automatic int h(input int i);
    int m;
    m = (i > 10 - i) ? 10 - i : i;
    case (m)
      0: h = 190;
      1: h = -32;
      2: h = 333;
      3: h = -154;
      4: h = 3096;
      default: h = 23977;
    endcase
  endfunction

  // R1 R2 R3 R4: filter one word against the model history
  function automatic logic [63:0] filt_word(input logic [63:0] d);
    int          x [14];
    logic [63:0] res;
    for (int j = 0; j < 10; j++) x[j] = mh[j];
    for (int n = 0; n < 4; n++) x[10+n] = int'($signed(d[n*16 +: 16]));
    for (int n = 0; n < 4; n++) begin
      longint      acc;
      logic [63:0] t;
      acc = 0;
      for (int i = 0; i < 11; i++) acc += longint'(h(i)) * longint'(x[10+n-i]);
      t = 64'(acc >>> 15);
      res[n*16 +: 16] = t[15:0];
    end
    for (int j = 0; j < 10; j++) mh[j] = x[j+4];
    return res;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h (edge %0d)", tag, what, act, exp, k);
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [63:0] d, input string tag);
    bit          forced;
    logic [63:0] ed;
    bit          ev;
    int          idx;
    @(negedge clk);
    k++;
    forced = 1'b0;
    for (int i = 0; i < 4; i++) forced |= ring_r[(k-i) & 7];
    ev = forced ? 1'b0 : ring_v[(k-3) & 7];
    ed = forced ? 64'd0 : ring_d[(k-3) & 7];
    check(forced ? "R8" : "R6", "out_valid", {63'd0, out_valid}, {63'd0, ev});
    check(forced ? "R8" : tag, "out_data", out_data, ed);
    rst = r;
    in_valid = v;
    in_data = d;
    idx = (k + 1) & 7;
    ring_r[idx] = r;
    if (r) begin
      for (int j = 0; j < 10; j++) mh[j] = 0;
      last_exp = '0;
      ring_v[idx] = 1'b0;
      ring_d[idx] = '0;
    end else if (v) begin
      last_exp = filt_word(d);
      ring_v[idx] = 1'b1;
      ring_d[idx] = last_exp;
    end else begin
      ring_v[idx] = 1'b0;   // R7: slot repeats the last word
      ring_d[idx] = last_exp;
    end
  endtask

  function automatic logic [63:0] mk(input int a, input int b, input int c, input int e);
    return {16'(e), 16'(c), 16'(b), 16'(a)};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    int seed_sink;
    seed_sink = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 8; i++) begin
      ring_r[i] = 1'b1;
      ring_v[i] = 1'b0;
      ring_d[i] = '0;
    end
    for (int j = 0; j < 10; j++) mh[j] = 0;

    // R8: reset state
    repeat (4) step(1, 0, '0, "R8");
    repeat (5) step(0, 0, '0, "R8");

    // R1 R2: impulse in lane 0 yields the coefficients in order
    step(0, 1, mk(32767, 0, 0, 0), "R2");
    repeat (4) step(0, 1, '0, "R1");
    // R3: impulse in lane 3 spreads across the next words
    step(0, 1, mk(0, 0, 0, 32767), "R3");
    repeat (4) step(0, 1, '0, "R3");
    // R9: zeros in a row
    repeat (6) step(0, 1, '0, "R9");

    // R4: full-scale constants and extreme alternation
    repeat (6) step(0, 1, mk(32767, 32767, 32767, 32767), "R4");
    repeat (6) step(0, 1, mk(-32768, -32768, -32768, -32768), "R4");
    repeat (6) step(0, 1, mk(32767, -32768, 32767, -32768), "R4");
    for (int i = 0; i < 40; i++) begin
      logic [63:0] w;
      for (int n = 0; n < 4; n++) w[n*16 +: 16] = $urandom_range(1) ? 16'h7fff : 16'h8000;
      step(0, 1, w, "R4");
    end

    // R5: continuous random stream
    for (int i = 0; i < 200; i++) step(0, 1, {$urandom, $urandom}, "R5");

    // R7: random gaps, plus impulses at lane 3 around gaps
    for (int i = 0; i < 200; i++)
      step(0, ($urandom_range(9) < 7), {$urandom, $urandom}, "R7");
    step(0, 1, mk(0, 0, 0, 20000), "R7");
    step(0, 0, {$urandom, $urandom}, "R7");
    step(0, 0, {$urandom, $urandom}, "R7");
    repeat (4) step(0, 1, '0, "R7");

    // R8: reset right after a gap, mid stream
    for (int i = 0; i < 6; i++) step(0, 1, {$urandom, $urandom}, "R5");
    step(0, 0, {$urandom, $urandom}, "R7");
    repeat (2) step(1, 1, {$urandom, $urandom}, "R8");
    for (int i = 0; i < 20; i++) step(0, 1, {$urandom, $urandom}, "R8");
    repeat (6) step(0, 0, '0, "R6");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule